// File: doc/BRIEF.md
# Beat-Wise Vector Predication Controller

This block sequences one vector instruction across four consecutive beats. Each beat handles one 32-bit quarter of a 128-bit vector. For every beat it forms a 4-bit element-enable mask from two registers: a 16-bit predicate register, with one 4-bit slice per beat, and an 8-bit mask register holding two 4-bit fields. Beats 0 and 1 use the low field. Beats 2 and 3 use the high field. The mask is presented to an external datapath together with the beat number and an execute strobe.

Between beats the predicate state moves forward. A field equal to `1000` marks the end of a predicated block and collapses to zero. A zero field stays as it is. Any other field shifts left by one. When the field's top bit is set, the beat's predicate slice is inverted first. The shifted field is stored back only on odd beats. The datapath can suppress this step for a beat.

The 32-bit beat result is merged into the 128-bit destination register. Only the bytes whose element bit is set are written. A load port sets the predicate and mask registers directly.

Top module: `vpred_beat_ctrl`

## Requirements
- R1: When idle, a `start` pulse raises `busy` and `beat_exec` on the next cycle. Beats 0, 1, 2 and 3 then follow on four consecutive cycles. `start` has no effect while `busy` is high.
- R2: `done` is high for exactly one cycle, in the cycle after beat 3. `busy` is low in that cycle.
- R3: A beat's field is `mask_q[3:0]` for beats 0 and 1 and `mask_q[7:4]` for beats 2 and 3. If that field is zero, `beat_mask` is `4'b1111`. Otherwise `beat_mask` is `pred_q[4b+3:4b]` for beat b.
- R4: If the field equals `4'b1000`, the advance step makes the working field zero and leaves `pred_q` unchanged.
- R5: If the field is zero, the advance step changes neither register.
- R6: For any other field, bit 3 set inverts the beat's 4-bit slice of `pred_q`, on even and odd beats alike. The working field becomes the field shifted left by one with a 0 at bit 0.
- R7: The working field is written into its half of `mask_q` only on beats 1 and 3. Beats 0 and 2 leave `mask_q` unchanged.
- R8: When `adv_clear` is high during a beat, that beat's advance step does not run. Both `pred_q` and `mask_q` keep their values.
- R9: In beat b, byte i of `beat_result` is written to `dest_q[32b+8i+7:32b+8i]` only when `beat_mask[i]` is 1. Every other byte of `dest_q` keeps its value.
- R10: `ld_en` loads `ld_pred` and `ld_mask` on the next edge and overrides any advance update in the same cycle. The destination write of that beat still takes place.
- R11: A synchronous `rst` clears `busy`, `done`, `pred_q`, `mask_q` and `dest_q`, including in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a four-beat sequence |
| ld_en | input | 1 | Load the predicate and mask registers |
| ld_pred | input | 16 | Predicate value to load |
| ld_mask | input | 8 | Mask value to load |
| adv_clear | input | 1 | Suppress the advance step for the current beat |
| beat_result | input | 32 | Datapath result for the current beat |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the last beat |
| beat_exec | output | 1 | Execute strobe for the current beat |
| beat_idx | output | 2 | Current beat number |
| beat_mask | output | 4 | Element enables for the current beat |
| pred_q | output | 16 | Predicate register |
| mask_q | output | 8 | Mask register |
| dest_q | output | 128 | Destination vector register |

## Verification
Assertions check the following on every cycle: that beats advance in order, that `done` is a single-cycle pulse, and that the mask register stays fixed on even beats. They also check that nothing changes when the advance step is suppressed, that the load port takes priority, and that each destination byte holds or takes the result according to its enable bit. Only the bench scenarios can show that the predicate and mask values are correct. This covers inverted slices, the terminal pattern collapsing to zero, shifted fields that are written back only on odd beats, and the element masks each beat derives from them. The bench scenarios also cover a reset in the middle of a sequence and a start request held high during a run.

// File: rtl/vpred_pkg.sv
package vpred_pkg;
    localparam int BEATS       = 4;
    localparam int LANES       = 4;
    localparam int BYTE_W      = 8;
    localparam int BEAT_W      = LANES * BYTE_W;
    localparam int VREG_W      = BEATS * BEAT_W;
    localparam int PRED_W      = BEATS * LANES;
    localparam int FIELD_W     = LANES;
    localparam int BEATS_PER_F = 2;
    localparam int FIELDS      = BEATS / BEATS_PER_F;
    localparam int MASK_W      = FIELDS * FIELD_W;
    localparam int BIDX_W      = $clog2(BEATS);
    localparam int FSEL_W      = (FIELDS > 1) ? $clog2(FIELDS) : 1;

    typedef logic [BIDX_W-1:0]  beat_t;
    typedef logic [LANES-1:0]   lane_mask_t;
    typedef logic [FIELD_W-1:0] field_t;

    localparam field_t TERM_PAT = field_t'(1) << (FIELD_W - 1);

    typedef struct packed {
        field_t work;
        logic   invert;
    } adv_res_t;

    function automatic adv_res_t advance_field(input field_t fld);
        adv_res_t r;
        r.invert = 1'b0;
        r.work   = fld;
        if (fld == TERM_PAT) begin
            r.work = '0;
        end else if (fld != '0) begin
            r.invert = fld[FIELD_W-1];
            r.work   = {fld[FIELD_W-2:0], 1'b0};
        end
        return r;
    endfunction

    function automatic logic [FSEL_W-1:0] field_of(input beat_t b);
        return FSEL_W'(int'(b) / BEATS_PER_F);
    endfunction
endpackage

// File: rtl/vpred_seq.sv
module vpred_seq
    import vpred_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output logic  busy,
    output logic  done,
    output beat_t beat
);
    localparam beat_t LAST = beat_t'(BEATS - 1);

    logic  busy_q, done_q;
    beat_t beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            beat_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    beat_q <= '0;
                end
            end else if (beat_q == LAST) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                beat_q <= '0;
            end else begin
                beat_q <= beat_q + beat_t'(1);
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign beat = beat_q;

    p_launch_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && start) |=> (busy_q && beat_q == '0));
    p_beat_step_r1: assert property (@(posedge clk) disable iff (rst)
        (busy_q && beat_q != LAST) |=> (busy_q && beat_q == beat_t'($past(beat_q) + beat_t'(1))));
    p_done_after_last_r2: assert property (@(posedge clk) disable iff (rst)
        (busy_q && beat_q == LAST) |=> (done_q && !busy_q));
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
endmodule

// File: rtl/vpred_pred_state.sv
module vpred_pred_state
    import vpred_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  beat_t             beat,
    input  logic              adv_clear,
    input  logic              ld_en,
    input  logic [PRED_W-1:0] ld_pred,
    input  logic [MASK_W-1:0] ld_mask,
    output lane_mask_t        beat_mask,
    output logic [PRED_W-1:0] pred_q,
    output logic [MASK_W-1:0] mask_q
);
    logic [PRED_W-1:0] pred_r, pred_nxt;
    logic [MASK_W-1:0] mask_r, mask_nxt;
    logic [FSEL_W-1:0] fsel;
    field_t            fld;
    lane_mask_t        slice;
    adv_res_t          adv;

    always_comb begin
        fsel      = field_of(beat);
        fld       = mask_r[int'(fsel)*FIELD_W +: FIELD_W];
        slice     = pred_r[int'(beat)*LANES +: LANES];
        beat_mask = (fld != '0) ? slice : '1;
        adv       = advance_field(fld);
        pred_nxt  = pred_r;
        mask_nxt  = mask_r;
        if (busy && !adv_clear) begin
            if (adv.invert)
                pred_nxt[int'(beat)*LANES +: LANES] = ~slice;
            if (beat[0])
                mask_nxt[int'(fsel)*FIELD_W +: FIELD_W] = adv.work;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_r <= '0;
            mask_r <= '0;
        end else if (ld_en) begin
            pred_r <= ld_pred;
            mask_r <= ld_mask;
        end else begin
            pred_r <= pred_nxt;
            mask_r <= mask_nxt;
        end
    end

    assign pred_q = pred_r;
    assign mask_q = mask_r;

    p_even_mask_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !beat[0] && !ld_en) |=> $stable(mask_r));
    p_adv_suppressed_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && adv_clear && !ld_en) |=> ($stable(pred_r) && $stable(mask_r)));
    p_load_wins_r10: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (pred_r == $past(ld_pred) && mask_r == $past(ld_mask)));
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && !ld_en) |=> ($stable(pred_r) && $stable(mask_r)));
endmodule

// File: rtl/vpred_wr_gate.sv
module vpred_wr_gate
    import vpred_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  beat_t             beat,
    input  lane_mask_t        lane_en,
    input  logic [BEAT_W-1:0] data,
    output logic [VREG_W-1:0] dest_q
);
    logic [VREG_W-1:0] dest_r, dest_nxt;

    always_comb begin
        dest_nxt = dest_r;
        for (int g = 0; g < BEATS; g++) begin
            for (int l = 0; l < LANES; l++) begin
                if (we && int'(beat) == g && lane_en[l])
                    dest_nxt[g*BEAT_W + l*BYTE_W +: BYTE_W] = data[l*BYTE_W +: BYTE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dest_r <= '0;
        else     dest_r <= dest_nxt;
    end

    assign dest_q = dest_r;

    p_idle_dest_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(dest_r));

    for (genvar g = 0; g < BEATS; g++) begin : g_beat
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            p_byte_hold_r9: assert property (@(posedge clk) disable iff (rst)
                (we && beat == beat_t'(g) && !lane_en[l])
                |=> $stable(dest_r[g*BEAT_W + l*BYTE_W +: BYTE_W]));
            p_byte_write_r9: assert property (@(posedge clk) disable iff (rst)
                (we && beat == beat_t'(g) && lane_en[l])
                |=> (dest_r[g*BEAT_W + l*BYTE_W +: BYTE_W] == $past(data[l*BYTE_W +: BYTE_W])));
        end
    end
endmodule

// File: rtl/vpred_beat_ctrl.sv
module vpred_beat_ctrl
    import vpred_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                ld_en,
    input  logic [PRED_W-1:0]   ld_pred,
    input  logic [MASK_W-1:0]   ld_mask,
    input  logic                adv_clear,
    input  logic [BEAT_W-1:0]   beat_result,
    output logic                busy,
    output logic                done,
    output logic                beat_exec,
    output logic [BIDX_W-1:0]   beat_idx,
    output logic [LANES-1:0]    beat_mask,
    output logic [PRED_W-1:0]   pred_q,
    output logic [MASK_W-1:0]   mask_q,
    output logic [VREG_W-1:0]   dest_q
);
    logic       busy_w;
    beat_t      beat_w;
    lane_mask_t lane_en;

    vpred_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy_w),
        .done  (done),
        .beat  (beat_w)
    );

    vpred_pred_state u_state (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy_w),
        .beat      (beat_w),
        .adv_clear (adv_clear),
        .ld_en     (ld_en),
        .ld_pred   (ld_pred),
        .ld_mask   (ld_mask),
        .beat_mask (lane_en),
        .pred_q    (pred_q),
        .mask_q    (mask_q)
    );

    vpred_wr_gate u_wr (
        .clk     (clk),
        .rst     (rst),
        .we      (busy_w),
        .beat    (beat_w),
        .lane_en (lane_en),
        .data    (beat_result),
        .dest_q  (dest_q)
    );

    assign busy      = busy_w;
    assign beat_exec = busy_w;
    assign beat_idx  = beat_w;
    assign beat_mask = lane_en;
endmodule

// File: tb/vpred_beat_ctrl_tb.sv
module vpred_beat_ctrl_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         start, ld_en, adv_clear;
    logic [15:0]  ld_pred;
    logic [7:0]   ld_mask;
    logic [31:0]  beat_result;
    logic         busy, done, beat_exec;
    logic [1:0]   beat_idx;
    logic [3:0]   beat_mask;
    logic [15:0]  pred_q;
    logic [7:0]   mask_q;
    logic [127:0] dest_q;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [15:0]  m_pred;
    logic [7:0]   m_mask;
    logic [127:0] m_dest;

    // {pred, mask, adv_clear per beat}
    localparam int NVEC = 8;
    localparam logic [27:0] VEC [NVEC] = '{
        {16'h1234, 8'h00, 4'b0000},
        {16'hA5C3, 8'h48, 4'b0000},
        {16'h0F0F, 8'h8C, 4'b0000},
        {16'hFFFF, 8'hFF, 4'b0000},
        {16'h1357, 8'h21, 4'b0101},
        {16'h8421, 8'h81, 4'b1111},
        {16'h0000, 8'hC6, 4'b0000},
        {16'h6E2B, 8'h3A, 4'b0010}
    };

    always #10 clk = ~clk;

    vpred_beat_ctrl u_dut (
        .clk(clk), .rst(rst), .start(start), .ld_en(ld_en), .ld_pred(ld_pred),
        .ld_mask(ld_mask), .adv_clear(adv_clear), .beat_result(beat_result),
        .busy(busy), .done(done), .beat_exec(beat_exec), .beat_idx(beat_idx),
        .beat_mask(beat_mask), .pred_q(pred_q), .mask_q(mask_q), .dest_q(dest_q)
    );

    task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference behaviour for one beat, written from the requirements.
    task automatic model_beat(input int b, input logic clr, input logic [31:0] res, output logic [3:0] em);
        logic [3:0] fld, sl, w;
        fld = (b < 2) ? m_mask[3:0] : m_mask[7:4];
        sl  = m_pred[4*b +: 4];
        em  = (fld != 4'h0) ? sl : 4'hF;
        for (int i = 0; i < 4; i++)
            if (em[i]) m_dest[32*b + 8*i +: 8] = res[8*i +: 8];
        if (!clr) begin
            w = 4'h0;
            if (fld != 4'b1000 && fld != 4'h0) begin
                if (fld[3]) m_pred[4*b +: 4] = ~sl;
                w = {fld[2:0], 1'b0};
            end
            if (b % 2 == 1) begin
                if (b < 2) m_mask[3:0] = w;
                else       m_mask[7:4] = w;
            end
        end
    endtask

    task automatic load(input logic [15:0] p, input logic [7:0] m);
        ld_en = 1'b1; ld_pred = p; ld_mask = m;
        @(negedge clk);
        ld_en = 1'b0;
        m_pred = p; m_mask = m;
    endtask

    task automatic run_instr(input int k, input logic [15:0] p, input logic [7:0] m,
                             input logic [3:0] clr, input logic hold_start);
        logic [3:0]  em;
        logic [31:0] res;
        load(p, m);
        start = 1'b1;
        @(negedge clk);
        if (!hold_start) start = 1'b0;
        for (int b = 0; b < 4; b++) begin
            res = {4{8'(16*k + 4*b)}} ^ 32'h0F1E2D3C;
            chk(busy && beat_exec && beat_idx == 2'(b), "R1 beat order", 128'(beat_idx), 128'(b));
            model_beat(b, clr[b], res, em);
            chk(beat_mask == em, "R3 element mask", 128'(beat_mask), 128'(em));
            adv_clear = clr[b];
            beat_result = res;
            @(negedge clk);
        end
        start = 1'b0;
        adv_clear = 1'b0;
        chk(done && !busy, "R2 done after beat 3", 128'({done, busy}), 128'(2'b10));
        chk(pred_q == m_pred, "R4 R5 R6 R8 predicate", 128'(pred_q), 128'(m_pred));
        chk(mask_q == m_mask, "R7 R4 R8 mask writeback", 128'(mask_q), 128'(m_mask));
        chk(dest_q == m_dest, "R9 destination bytes", dest_q, m_dest);
        @(negedge clk);
        chk(!done && !busy, "R2 R1 single done, start ignored", 128'({done, busy}), 128'(0));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; ld_en = 1'b0; adv_clear = 1'b0;
        ld_pred = '0; ld_mask = '0; beat_result = '0;
        m_pred = '0; m_mask = '0; m_dest = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!busy && !done && !beat_exec, "R11 reset control", 128'({busy, done, beat_exec}), 128'(0));
        chk(pred_q == 0 && mask_q == 0 && dest_q == 0, "R11 reset registers",
            128'({pred_q, mask_q}), 128'(0));

        // table walk
        for (int k = 0; k < NVEC; k++)
            run_instr(k, VEC[k][27:12], VEC[k][11:4], VEC[k][3:0], 1'b0);

        // start held high through a run (R1)
        run_instr(9, 16'h5A5A, 8'h99, 4'b0000, 1'b1);

        // R10: load during beat 1 overrides advance, write still happens
        load(16'hFFFF, 8'h22);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        beat_result = 32'h01020304;
        @(negedge clk);
        ld_en = 1'b1; ld_pred = 16'h0001; ld_mask = 8'h00;
        beat_result = 32'hCAFEBABE;
        @(negedge clk);
        ld_en = 1'b0;
        chk(pred_q == 16'h0001 && mask_q == 8'h00, "R10 load priority",
            128'({pred_q, mask_q}), 128'({16'h0001, 8'h00}));
        chk(dest_q[63:32] == 32'hCAFEBABE, "R10 write during load", 128'(dest_q[63:32]), 128'(32'hCAFEBABE));
        chk(beat_idx == 2'd2 && beat_mask == 4'hF, "R3 R10 mask after load",
            128'({beat_idx, beat_mask}), 128'({2'd2, 4'hF}));
        repeat (3) @(negedge clk);

        // R11: reset in the middle of a sequence
        load(16'h1111, 8'h11);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && !done, "R11 mid-run reset control", 128'({busy, done}), 128'(0));
        chk(pred_q == 0 && mask_q == 0 && dest_q == 0, "R11 mid-run reset registers",
            128'(dest_q), 128'(0));
        @(negedge clk);
        chk(!busy && !done, "R11 stays idle after reset", 128'({busy, done}), 128'(0));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule